// File: doc/BRIEF.md
# Daisy-Chain DAC Serial Host Controller

This block is the host end of a serial link to a chain of four-channel DAC devices. All devices share one serial clock and one active-low select/load line. Each device's data output feeds the next device's data input. A transaction request carries one command, address and data triple for every device position, plus an enable bit per position. The controller turns the request into one bit stream of 32-bit words and shifts it out MSB first. It then raises the select line so that every device in the chain executes its word on the same edge.

Each 32-bit word starts with eight zero padding bits. The 4-bit command follows, then the 4-bit address, then the 16 data bits. The word for the device farthest from the host goes out first. A position whose enable bit is clear gets a no-operation word. The serial clock is the system clock divided down. Every minimum gap around the select line is a count of system clock cycles, derived from a clock-period parameter. While the frame shifts out, the bits returning from the far end of the chain are captured and returned when the transaction finishes.

Top module: `dcm_chain_master`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` asserted while a transaction is in progress has no effect: no extra select cycle and no change to the words shifted out.
- R2: Every transaction produces exactly 32×NUM_DEV rising edges of `sclk`, all while `csel_n` is low.
- R3: Each 32-bit word is sent MSB first. Word bits 31..24 are 0, bits 23..20 are the command, bits 19..16 are the address and bits 15..0 are the data.
- R4: Device position NUM_DEV-1 (farthest from the host) is sent first and position 0 (nearest) last. Position k takes its fields from `req_cmd[4k+:4]`, `req_addr[4k+:4]` and `req_data[16k+:16]`.
- R5: A position whose `req_en` bit is 0 receives command 4'hF, address 4'hF and data 16'h0000.
- R6: `mosi` only changes while `sclk` is low. It is constant through every `sclk` high phase.
- R7: `csel_n` falls on the cycle after acceptance. It then stays low for LEAD + SCK_HALF cycles before the first `sclk` rise, where LEAD = max(1, ceil(T_LEAD_PS/CLK_PERIOD_PS)). `csel_n` only changes while `sclk` is low.
- R8: From the last `sclk` rise, `csel_n` stays low for SCK_HALF + TRAIL cycles, where TRAIL = max(1, ceil(T_TRAIL_PS/CLK_PERIOD_PS)).
- R9: After `csel_n` rises, it stays high for HOLD cycles, where HOLD = max(1, ceil(T_HIGH_PS/P), ceil(T_NEXT_PS/P)). `done` is then high for exactly one cycle, in the same cycle that `req_ready` returns high.
- R10: `miso` is sampled on each `sclk` rising edge. When `done` is high, `rd_data` holds the 32×NUM_DEV sampled bits, with the first bit sampled at bit 32×NUM_DEV-1.
- R11: While reset is applied and after it, before any request: `csel_n`=1, `sclk`=0, `req_ready`=1 and `done`=0.
- R12: Each `sclk` period is 2×SCK_HALF system clock cycles, so consecutive rising edges within a frame are 2×SCK_HALF cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_en | input | NUM_DEV | Per-position enable; clear means no-operation |
| req_cmd | input | 4×NUM_DEV | Per-position command nibble |
| req_addr | input | 4×NUM_DEV | Per-position address nibble |
| req_data | input | 16×NUM_DEV | Per-position data word |
| sclk | output | 1 | Serial clock to all devices |
| csel_n | output | 1 | Shared select/load, low during shifting |
| mosi | output | 1 | Serial data to the first device in the chain |
| miso | input | 1 | Serial data from the last device in the chain |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| rd_data | output | 32×NUM_DEV | Bits captured from `miso` during the last transaction |

## Verification
The bench builds the controller with three device positions, SCK_HALF of 2 and an 8 ns clock period. Three positions put one device between the first-sent and last-sent slots, so ordering errors cannot hide behind a symmetric two-word swap. A divide of two gives multi-cycle high and low phases, so data stability inside a high phase and the phase lengths can be observed. At 8 ns the 7 ns gaps round up to one cycle and the 10 ns high time rounds up to two cycles, which exercises the ceiling and maximum rules.

// File: rtl/dcm_pkg.sv
// Shared constants, types and helpers for the daisy-chain DAC host controller.
// Assumes a fixed 32-bit per-device word: 8 pad bits, command, address, data.
package dcm_pkg;

    localparam int WORD_BITS = 32;
    localparam int PAD_BITS  = 8;
    localparam logic [3:0] NOP_CMD  = 4'hF;
    localparam logic [3:0] NOP_ADDR = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_HOLD
    } dcm_state_e;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [3:0]  addr;
        logic [15:0] data;
    } dcm_req_t;

    // Build one device word with its leading zero pad.
    function automatic logic [WORD_BITS-1:0] pack_word(input dcm_req_t r);
        return {{PAD_BITS{1'b0}}, r.cmd, r.addr, r.data};
    endfunction

    // Round a picosecond gap up to whole clock cycles, never below one.
    function automatic int gap_cycles(input int gap_ps, input int period_ps);
        int c;
        c = (gap_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dcm_frame_builder.sv
// Builds the full chain frame from per-position request fields.
// Position NUM_DEV-1 lands in the top word so it is shifted out first;
// disabled positions are filled with a no-operation word.
// Purely combinational; assumes inputs are held stable while loaded.
module dcm_frame_builder
    import dcm_pkg::*;
#(
    parameter int NUM_DEV = 3
) (
    input  logic [NUM_DEV-1:0]           en,
    input  logic [4*NUM_DEV-1:0]         cmd,
    input  logic [4*NUM_DEV-1:0]         addr,
    input  logic [16*NUM_DEV-1:0]        data,
    output logic [WORD_BITS*NUM_DEV-1:0] frame
);

    genvar g;
    generate
        for (g = 0; g < NUM_DEV; g++) begin : g_slot
            dcm_req_t slot;

            // Select the requested fields or the no-operation filler.
            always_comb begin
                if (en[g]) begin
                    slot.cmd  = cmd[4*g +: 4];
                    slot.addr = addr[4*g +: 4];
                    slot.data = data[16*g +: 16];
                end else begin
                    slot.cmd  = NOP_CMD;
                    slot.addr = NOP_ADDR;
                    slot.data = 16'h0000;
                end
            end

            assign frame[WORD_BITS*g +: WORD_BITS] = pack_word(slot);
        end
    endgenerate

endmodule

// File: rtl/dcm_sck_gen.sv
// Serial clock divider. While run is high it produces a clock that is low
// for HALF cycles and then high for HALF cycles, starting low, with strobes
// in the cycle just before each rise and each fall. Idles low when run is low.
module dcm_sck_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_stb,
    output logic fall_stb
);

    localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [PW-1:0] ph;
    logic          ph_last;

    assign ph_last  = (ph == PW'(HALF - 1));
    assign rise_stb = run && !sclk && ph_last;
    assign fall_stb = run &&  sclk && ph_last;

    // Phase counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph   <= '0;
            sclk <= 1'b0;
        end else if (ph_last) begin
            ph   <= '0;
            sclk <= ~sclk;
        end else begin
            ph   <= ph + 1'b1;
        end
    end

    // R12: a rise strobe is always followed by a high clock, and a fall by a low one.
    p_rise_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> sclk);
    p_fall_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !sclk);

endmodule

// File: rtl/dcm_shifter.sv
// Transmit and receive shift registers for one chain frame. The transmit side
// loads the whole frame and moves one bit up on each shift strobe (MSB out).
// The receive side appends miso on each sample strobe, so the first sampled
// bit ends at the top after W samples.
module dcm_shifter #(
    parameter int W = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] frame,
    input  logic         shift,
    input  logic         sample,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] rx
);

    logic [W-1:0] tx;

    assign mosi = tx[W-1];

    // Transmit register: load a frame or advance one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     tx <= '0;
        else if (load)  tx <= frame;
        else if (shift) tx <= {tx[W-2:0], 1'b0};
    end

    // Receive register: capture returning bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      rx <= '0;
        else if (sample) rx <= {rx[W-2:0], miso};
    end

    // R1: a new frame is never loaded in the middle of shifting.
    p_load_not_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && (shift || sample)));

endmodule

// File: rtl/dcm_chain_master.sv
// Host controller for a daisy chain of serial DACs. It accepts one request
// per transaction when idle, shifts a 32-bit word per position with the
// farthest position first, then raises the shared select/load line and
// pulses done once the minimum high time has passed. All select gaps are
// whole system clock cycles derived from the clock-period parameter.
module dcm_chain_master
    import dcm_pkg::*;
#(
    parameter int NUM_DEV       = 3,
    parameter int SCK_HALF      = 2,
    parameter int CLK_PERIOD_PS = 8000,
    parameter int T_LEAD_PS     = 7000,
    parameter int T_TRAIL_PS    = 7000,
    parameter int T_HIGH_PS     = 10000,
    parameter int T_NEXT_PS     = 7000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [NUM_DEV-1:0]            req_en,
    input  logic [4*NUM_DEV-1:0]          req_cmd,
    input  logic [4*NUM_DEV-1:0]          req_addr,
    input  logic [16*NUM_DEV-1:0]         req_data,
    output logic                          sclk,
    output logic                          csel_n,
    output logic                          mosi,
    input  logic                          miso,
    output logic                          done,
    output logic [WORD_BITS*NUM_DEV-1:0]  rd_data
);

    localparam int TOTAL_BITS = WORD_BITS * NUM_DEV;
    localparam int LEAD_CYC   = gap_cycles(T_LEAD_PS, CLK_PERIOD_PS);
    localparam int TRAIL_CYC  = gap_cycles(T_TRAIL_PS, CLK_PERIOD_PS);
    localparam int HOLD_CYC   = max2(gap_cycles(T_HIGH_PS, CLK_PERIOD_PS),
                                     gap_cycles(T_NEXT_PS, CLK_PERIOD_PS));
    localparam int MAX_GAP    = max2(max2(LEAD_CYC, TRAIL_CYC), HOLD_CYC);
    localparam int TCW        = $clog2(MAX_GAP + 1);
    localparam int BCW        = $clog2(TOTAL_BITS + 1);

    dcm_state_e          state;
    logic [TCW-1:0]      tcnt;
    logic [BCW-1:0]      bitcnt;
    logic                accept;
    logic                run;
    logic                rise_stb;
    logic                fall_stb;
    logic [TOTAL_BITS-1:0] frame;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign run       = (state == ST_SHIFT);

    dcm_frame_builder #(.NUM_DEV(NUM_DEV)) u_build (
        .en    (req_en),
        .cmd   (req_cmd),
        .addr  (req_addr),
        .data  (req_data),
        .frame (frame)
    );

    dcm_sck_gen #(.HALF(SCK_HALF)) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sclk     (sclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    dcm_shifter #(.W(TOTAL_BITS)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .frame  (frame),
        .shift  (fall_stb),
        .sample (rise_stb),
        .miso   (miso),
        .mosi   (mosi),
        .rx     (rd_data)
    );

    // Transaction sequencer: select lead, shifting, trailing gap, high hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tcnt   <= '0;
            bitcnt <= '0;
            csel_n <= 1'b1;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state  <= ST_LEAD;
                        csel_n <= 1'b0;
                        tcnt   <= '0;
                        bitcnt <= '0;
                    end
                end
                ST_LEAD: begin
                    if (tcnt == TCW'(LEAD_CYC - 1)) begin
                        state <= ST_SHIFT;
                        tcnt  <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (fall_stb) begin
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == BCW'(TOTAL_BITS - 1)) begin
                            state <= ST_TRAIL;
                            tcnt  <= '0;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tcnt == TCW'(TRAIL_CYC - 1)) begin
                        state  <= ST_HOLD;
                        csel_n <= 1'b1;
                        tcnt   <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (tcnt == TCW'(HOLD_CYC - 1)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: after acceptance the controller is busy and the select is low.
    p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!req_ready && !csel_n));

    // R2: the bit count never passes the frame length.
    p_bit_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= BCW'(TOTAL_BITS));

    // R6: data is held through every high phase of the serial clock.
    p_mosi_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R7: the select line moves only while the serial clock is low.
    p_sel_edge_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(csel_n) |-> !sclk);

    // R9: done appears with the select high and the controller idle.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (csel_n && req_ready && !sclk));

    // R11: the serial clock never runs while the select is high.
    p_idle_clock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        csel_n |-> !sclk);

endmodule

// File: tb/dcm_chain_master_test.sv
`timescale 1ns/1ps
module dcm_chain_master_test;

    localparam int N      = 3;
    localparam int H      = 2;
    localparam int PER_PS = 8000;
    localparam int W      = 32 * N;
    localparam int LEAD   = (7000 + PER_PS - 1) / PER_PS;
    localparam int TRAIL  = (7000 + PER_PS - 1) / PER_PS;
    localparam int HOLD   = ((10000 + PER_PS - 1) / PER_PS > (7000 + PER_PS - 1) / PER_PS)
                            ? (10000 + PER_PS - 1) / PER_PS : (7000 + PER_PS - 1) / PER_PS;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [N-1:0]   req_en = '0;
    logic [4*N-1:0] req_cmd = '0;
    logic [4*N-1:0] req_addr = '0;
    logic [16*N-1:0] req_data = '0;
    logic           sclk, csel_n, mosi, done;
    logic           miso = 1'b0;
    logic [W-1:0]   rd_data;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    int txns = 0;
    int sel_falls = 0;
    logic [31:0] exp_q[$];
    logic [W-1:0] miso_pat = '0;
    int miso_idx = 0;

    always #4 clk = ~clk;

    dcm_chain_master #(.NUM_DEV(N), .SCK_HALF(H), .CLK_PERIOD_PS(PER_PS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_en(req_en), .req_cmd(req_cmd), .req_addr(req_addr), .req_data(req_data),
        .sclk(sclk), .csel_n(csel_n), .mosi(mosi), .miso(miso),
        .done(done), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_test();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Far end of the chain: present the next pattern bit after each falling edge.
    always @(negedge sclk) begin
        if (miso_idx < W - 1) begin
            miso_idx = miso_idx + 1;
            miso = miso_pat[W - 1 - miso_idx];
        end
    end

    // Monitor: rebuild words at sclk rises and compare against the scoreboard.
    logic [31:0] acc = '0;
    int nbit = 0;
    int since_rise = -1;
    logic m_sck = 1'b0;
    logic m_sel = 1'b1;
    logic rise_mosi = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!csel_n && m_sel) sel_falls++;
            if (csel_n) begin
                since_rise = -1;
                nbit = 0;
            end else if (since_rise >= 0) begin
                since_rise++;
            end
            if (sclk && !m_sck) begin
                if (since_rise > 0)
                    chk(since_rise == 2 * H, "R12 rise spacing", since_rise, 2 * H);
                since_rise = 0;
                rise_mosi = mosi;
                acc = {acc[30:0], mosi};
                nbit++;
                if (nbit % 32 == 0) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 unexpected word", acc, 0);
                    end else begin
                        logic [31:0] e;
                        e = exp_q.pop_front();
                        chk(acc == e, "R3/R4/R5 word", acc, e);
                    end
                end
            end else if (sclk && m_sck) begin
                chk(mosi == rise_mosi, "R6 mosi in high phase", mosi, rise_mosi);
            end
            m_sck = sclk;
            m_sel = csel_n;
        end
    end

    // Driver: queue expected words, run one transaction, check its timing.
    task automatic run_txn(input logic [N-1:0] en, input logic [4*N-1:0] cmd,
                           input logic [4*N-1:0] addr, input logic [16*N-1:0] data,
                           input logic [W-1:0] pat, input bit poke);
        int lead = 0, rises = 0, trail = 0, hold = 0, cyc = 0;
        bit seen = 0;
        logic psck = 1'b0;
        for (int d = N - 1; d >= 0; d--) begin
            if (en[d]) exp_q.push_back({8'h00, cmd[4*d +: 4], addr[4*d +: 4], data[16*d +: 16]});
            else       exp_q.push_back({8'h00, 4'hF, 4'hF, 16'h0000});
        end
        miso_pat = pat;
        miso_idx = 0;
        miso = pat[W - 1];
        @(negedge clk);
        req_en = en; req_cmd = cmd; req_addr = addr; req_data = data;
        req_valid = 1'b1;
        txns++;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                chk(!req_ready, "R1 ready low while busy", req_ready, 0);
                if (poke) begin
                    req_en = '1; req_cmd = '0; req_addr = '0; req_data = '1;
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (poke && cyc == 10) req_valid = 1'b0;
            if (!seen && !csel_n && !sclk) lead++;
            if (sclk && !psck) begin
                rises++;
                seen = 1;
                trail = 0;
            end
            if (!csel_n && seen) trail++;
            if (csel_n && !done) hold++;
            psck = sclk;
            if (done || cyc > 5000) break;
        end
        chk(lead == LEAD + H, "R7 select lead", lead, LEAD + H);
        chk(rises == W, "R2 sclk rises", rises, W);
        chk(trail == H + TRAIL, "R8 select trail", trail, H + TRAIL);
        chk(hold == HOLD, "R9 select high before done", hold, HOLD);
        chk(req_ready, "R9 ready with done", req_ready, 1);
        chk(rd_data == pat, "R10 readback", rd_data, pat);
        chk(exp_q.size() == 0, "R2 words per frame", exp_q.size(), 0);
        @(negedge clk);
        chk(!done, "R9 done single pulse", done, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_test();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(csel_n == 1'b1, "R11 select in reset", csel_n, 1);
        chk(sclk == 1'b0, "R11 sclk in reset", sclk, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);
        chk(done == 1'b0, "R11 done after reset", done, 0);
        chk(csel_n == 1'b1 && sclk == 1'b0, "R11 idle lines", {csel_n, sclk}, 2'b10);

        // All positions enabled, distinct fields (R3, R4).
        run_txn(3'b111, {4'h3, 4'h3, 4'h3}, {4'h2, 4'h1, 4'h0},
                {16'hC0DE, 16'h1234, 16'hA5F0}, {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF}, 0);
        // Middle position only; valid poked while busy (R1, R5).
        run_txn(3'b010, {4'h0, 4'h1, 4'h0}, {4'h0, 4'h3, 4'h0},
                {16'h0000, 16'h8001, 16'h0000}, {32'h0F0F0F0F, 32'hF0F0F0F0, 32'h55AA55AA}, 1);
        repeat (20) @(negedge clk);
        chk(sel_falls == txns, "R1 no extra transaction", sel_falls, txns);
        chk(csel_n == 1'b1, "R1 select stays high", csel_n, 1);
        // No position enabled: every word is a no-operation (R5).
        run_txn(3'b000, '1, '1, '1, {W{1'b1}}, 0);
        // Outer positions, power-down style command on all channels (R4).
        run_txn(3'b101, {4'h4, 4'h0, 4'h2}, {4'hF, 4'h0, 4'h3},
                {16'hFFFF, 16'h0000, 16'h0001}, {32'h80000001, 32'h00000000, 32'hFFFFFFFE}, 0);
        chk(sel_falls == txns, "R2 one select per request", sel_falls, txns);
        finish_test();
    end

endmodule